// File: doc/BRIEF.md
# Error Correction Applier

This block runs the repair step that follows a four-symbol BCH-style decoder on a 512-byte sector. The decoder computes the syndromes and the error locations; this block drives it through its start-up, reads its state, and then patches the sector buffer. When a run is started and the syndromes are already all zero, nothing has to be repaired and the run ends at once. Otherwise the block issues a clearing read of the first address register, then a start pulse to the decoder. It then waits until the decoder truly reports "working". Right after the start pulse the decoder's state field can show a false "finished" code, so that early value is ignored. A timeout bounds this wait.

Once the decoder reports that addresses are ready, the block takes the error count and reads each location/value pair. Pairs are packed two per result register. Each location is stored reversed and biased, so the block turns it into a byte offset. For every offset inside the sector it does a read-modify-write of the sector RAM, one byte at a time. Offsets that land in the check bytes are skipped. A one-cycle completion pulse comes with a status that holds until the next run: the count of repaired bytes, an uncorrectable flag, or a timeout flag.

Top module: `corr_apply`

## Requirements
- R1: A `start` with `syn_zero` high raises `done` in the next cycle with `fix_cnt` = 0 and both flags low, with no decoder pulse and no RAM access.
- R2: A `start` with `syn_zero` low gives a one-cycle `clr_rd` pulse in the next cycle, then a one-cycle `calc_go` pulse in the cycle after that.
- R3: During the arming wait that follows `calc_go`, any `dec_state` below 4 (including 3) is ignored. A value of 4 or more ends the wait and starts polling.
- R4: If `dec_state` stays below 4 for TMO_CYC arming cycles, `done` rises with `timed_out` = 1 and `fix_cnt` = 0. A 4 seen in the last of those cycles still arms, because arming wins over the timeout.
- R5: While polling, `dec_state` = 0 or 1 gives one `rel_rd` pulse and then `done`. The value 1 sets `uncorr`; the value 0 ends cleanly with `fix_cnt` = 0. A value of 4 or more keeps the block polling with no RAM access.
- R6: When polling sees `dec_state` 2 or 3, the number of errors is `dec_cnt` + 1. `dec_cnt` is sampled in that cycle.
- R7: Error k (k = 0..3) is taken from result register `res_sel` = k/2. Even k uses bits [15:0] and odd k uses bits [31:16] of `res_loc` and `res_val`. The location is bits [9:0] of its half and the value is bits [7:0] of its half.
- R8: The byte offset is 519 minus the location. If that offset lies in 0..511, the byte is read (`ram_rd`) and, in the next cycle, written at the same address with read data XOR value. Any other location is skipped with no RAM access.
- R9: `fix_cnt` equals the number of bytes written in the run. `done` is a one-cycle pulse. `fix_cnt`, `uncorr` and `timed_out` hold their value until the next `start`.
- R10: At most one of `clr_rd`, `calc_go`, `rel_rd`, `ram_rd`, `ram_wr` is high in any cycle, and `ram_wr` comes only in the cycle right after `ram_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a correction run (accepted while idle) |
| syn_zero | input | 1 | All four syndromes are zero |
| dec_state | input | 4 | Decoder state field |
| dec_cnt | input | 2 | Decoder error-count field (errors minus one) |
| clr_rd | output | 1 | Clearing read of the first address register |
| calc_go | output | 1 | Address-calculation start pulse |
| rel_rd | output | 1 | Releasing read of the first value register |
| res_sel | output | 1 | Result register pair selector |
| res_loc | input | 32 | Selected location register, two packed halves |
| res_val | input | 32 | Selected value register, two packed halves |
| ram_addr | output | 9 | Sector RAM byte address |
| ram_rd | output | 1 | Sector RAM read strobe (data valid next cycle) |
| ram_wr | output | 1 | Sector RAM write strobe |
| ram_wdata | output | 8 | Sector RAM write data |
| ram_rdata | input | 8 | Sector RAM read data |
| done | output | 1 | One-cycle completion pulse |
| fix_cnt | output | 3 | Bytes repaired in the last run |
| uncorr | output | 1 | Last run found too many errors |
| timed_out | output | 1 | Last run never saw the decoder arm |

## Verification
The arming wait and the timeout can land on the same cycle. This happens when the decoder first reports 4 or more on the very last cycle the timer allows. The bench counts negedges from the observed `calc_go` pulse and raises the state on exactly that cycle. It expects a normal completion with no timeout flag. In a second run it raises the state one cycle later and expects the timeout flag with `done`. A repair write and the next location fetch can never share a cycle, and the bench judges this by tallying overlapping strobes and the number of writes in every run.

// File: rtl/corr_apply_pkg.sv
package corr_apply_pkg;

    // Decoder state codes the applier reacts to
    localparam int DS_CLEAN = 0;
    localparam int DS_MANY  = 1;
    localparam int DS_BUSY  = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLR,
        ST_GO,
        ST_ARM,
        ST_POLL,
        ST_REL,
        ST_FETCH,
        ST_RD,
        ST_WR
    } fsm_t;

endpackage

// File: rtl/corr_apply_timer.sv
module corr_apply_timer #(
    parameter int LIMIT = 25000,
    localparam int TW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic last
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run && !last) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // High during the final cycle of the allowed window
    assign last = (cnt_q == TW'(LIMIT - 1));

endmodule

// File: rtl/corr_apply_locmap.sv
module corr_apply_locmap #(
    parameter int SECT_BYTES = 512,
    parameter int LOC_BIAS   = 519,
    parameter int LOC_W      = 10,
    parameter int HALF_W     = 16,
    parameter int DATA_W     = 8,
    localparam int ADDR_W    = $clog2(SECT_BYTES),
    localparam int REG_W     = 2 * HALF_W,
    localparam int WIDE      = LOC_W + 2
) (
    input  logic [REG_W-1:0]  loc_word,
    input  logic [REG_W-1:0]  val_word,
    input  logic              upper,
    output logic [ADDR_W-1:0] offset,
    output logic              in_sector,
    output logic [DATA_W-1:0] flip
);

    logic [HALF_W-1:0] loc_half, val_half;
    logic [LOC_W-1:0]  loc;
    logic [WIDE-1:0]   loc_w, bias_w, diff;

    always_comb begin
        loc_half  = upper ? loc_word[REG_W-1 -: HALF_W] : loc_word[HALF_W-1:0];
        val_half  = upper ? val_word[REG_W-1 -: HALF_W] : val_word[HALF_W-1:0];
        loc       = LOC_W'(loc_half);
        flip      = DATA_W'(val_half);
        loc_w     = WIDE'(loc);
        bias_w    = WIDE'(LOC_BIAS);
        diff      = bias_w - loc_w;
        in_sector = (loc_w <= bias_w) && (diff < WIDE'(SECT_BYTES));
        offset    = ADDR_W'(diff);
    end

endmodule

// File: rtl/corr_apply.sv
module corr_apply
    import corr_apply_pkg::*;
#(
    parameter int SECT_BYTES = 512,
    parameter int LOC_BIAS   = 519,
    parameter int LOC_W      = 10,
    parameter int HALF_W     = 16,
    parameter int DATA_W     = 8,
    parameter int MAX_ERR    = 4,
    parameter int DEC_W      = 4,
    parameter int TMO_CYC    = 25000,
    localparam int ADDR_W    = $clog2(SECT_BYTES),
    localparam int REG_W     = 2 * HALF_W,
    localparam int IDX_W     = $clog2(MAX_ERR),
    localparam int CNT_W     = $clog2(MAX_ERR + 1),
    localparam int NREG      = MAX_ERR / 2,
    localparam int SEL_W     = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              syn_zero,
    input  logic [DEC_W-1:0]  dec_state,
    input  logic [IDX_W-1:0]  dec_cnt,
    output logic              clr_rd,
    output logic              calc_go,
    output logic              rel_rd,
    output logic [SEL_W-1:0]  res_sel,
    input  logic [REG_W-1:0]  res_loc,
    input  logic [REG_W-1:0]  res_val,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_rd,
    output logic              ram_wr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              done,
    output logic [CNT_W-1:0]  fix_cnt,
    output logic              uncorr,
    output logic              timed_out
);

    typedef struct packed {
        fsm_t              st;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last;
        logic [ADDR_W-1:0] off;
        logic [DATA_W-1:0] val;
        logic [CNT_W-1:0]  fixc;
        logic              uncorr;
        logic              tmo;
        logic              done;
    } regs_t;

    regs_t r_d, r_q;

    logic              tmr_last;
    logic [ADDR_W-1:0] map_off;
    logic              map_hit;
    logic [DATA_W-1:0] map_val;
    logic              busy_code;
    logic              ready_code;

    corr_apply_timer #(
        .LIMIT (TMO_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (r_q.st == ST_GO),
        .run   (r_q.st == ST_ARM),
        .last  (tmr_last)
    );

    corr_apply_locmap #(
        .SECT_BYTES (SECT_BYTES),
        .LOC_BIAS   (LOC_BIAS),
        .LOC_W      (LOC_W),
        .HALF_W     (HALF_W),
        .DATA_W     (DATA_W)
    ) u_locmap (
        .loc_word  (res_loc),
        .val_word  (res_val),
        .upper     (r_q.idx[0]),
        .offset    (map_off),
        .in_sector (map_hit),
        .flip      (map_val)
    );

    assign busy_code  = (dec_state >= DEC_W'(DS_BUSY));
    assign ready_code = !busy_code && (dec_state > DEC_W'(DS_MANY));

    always_comb begin
        logic step;
        r_d      = r_q;
        r_d.done = 1'b0;
        step     = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.fixc   = '0;
                    r_d.uncorr = 1'b0;
                    r_d.tmo    = 1'b0;
                    if (syn_zero) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st = ST_CLR;
                    end
                end
            end
            ST_CLR:  r_d.st = ST_GO;
            ST_GO:   r_d.st = ST_ARM;
            ST_ARM: begin
                // a real busy code wins over an expiring window
                if (busy_code) begin
                    r_d.st = ST_POLL;
                end else if (tmr_last) begin
                    r_d.tmo  = 1'b1;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            ST_POLL: begin
                if (dec_state == DEC_W'(DS_CLEAN)) begin
                    r_d.st = ST_REL;
                end else if (dec_state == DEC_W'(DS_MANY)) begin
                    r_d.uncorr = 1'b1;
                    r_d.st     = ST_REL;
                end else if (ready_code) begin
                    r_d.last = dec_cnt;
                    r_d.idx  = '0;
                    r_d.st   = ST_FETCH;
                end
            end
            ST_REL: begin
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            ST_FETCH: begin
                r_d.off = map_off;
                r_d.val = map_val;
                if (map_hit) begin
                    r_d.st = ST_RD;
                end else begin
                    step = 1'b1;
                end
            end
            ST_RD:   r_d.st = ST_WR;
            ST_WR: begin
                r_d.fixc = r_q.fixc + 1'b1;
                step     = 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (step) begin
            if (r_q.idx == r_q.last) begin
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end else begin
                r_d.idx = r_q.idx + 1'b1;
                r_d.st  = ST_FETCH;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign clr_rd    = (r_q.st == ST_CLR);
    assign calc_go   = (r_q.st == ST_GO);
    assign rel_rd    = (r_q.st == ST_REL);
    assign res_sel   = SEL_W'(r_q.idx >> 1);
    assign ram_addr  = r_q.off;
    assign ram_rd    = (r_q.st == ST_RD);
    assign ram_wr    = (r_q.st == ST_WR);
    assign ram_wdata = ram_rdata ^ r_q.val;
    assign done      = r_q.done;
    assign fix_cnt   = r_q.fixc;
    assign uncorr    = r_q.uncorr;
    assign timed_out = r_q.tmo;

endmodule

// File: rtl/corr_apply_chk.sv
module corr_apply_chk #(
    parameter int SECT_BYTES = 512,
    parameter int DATA_W     = 8,
    parameter int MAX_ERR    = 4,
    localparam int ADDR_W    = $clog2(SECT_BYTES),
    localparam int CNT_W     = $clog2(MAX_ERR + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_rd,
    input logic              calc_go,
    input logic              rel_rd,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_rd,
    input logic              ram_wr,
    input logic              done,
    input logic [CNT_W-1:0]  fix_cnt,
    input logic              uncorr,
    input logic              timed_out
);

    p_go_after_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        calc_go |-> $past(clr_rd));

    p_release_then_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rel_rd |=> done);

    p_write_follows_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |-> ($past(ram_rd) && ram_addr == $past(ram_addr)));

    p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(uncorr && timed_out));

    p_flag_zero_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (uncorr || timed_out)) |-> (fix_cnt == '0));

    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fix_cnt <= CNT_W'(MAX_ERR));

    p_one_action_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clr_rd, calc_go, rel_rd, ram_rd, ram_wr}));

endmodule

bind corr_apply corr_apply_chk #(
    .SECT_BYTES (SECT_BYTES),
    .DATA_W     (DATA_W),
    .MAX_ERR    (MAX_ERR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_rd    (clr_rd),
    .calc_go   (calc_go),
    .rel_rd    (rel_rd),
    .ram_addr  (ram_addr),
    .ram_rd    (ram_rd),
    .ram_wr    (ram_wr),
    .done      (done),
    .fix_cnt   (fix_cnt),
    .uncorr    (uncorr),
    .timed_out (timed_out)
);

// File: tb/corr_apply_bench.sv
module corr_apply_bench;

    localparam int TMO  = 20;
    localparam int SECT = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        syn_zero = 1'b0;
    logic [3:0]  dec_state = 4'd0;
    logic [1:0]  dec_cnt = 2'd0;
    logic        clr_rd, calc_go, rel_rd;
    logic [0:0]  res_sel;
    logic [31:0] res_loc, res_val;
    logic [8:0]  ram_addr;
    logic        ram_rd, ram_wr;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata = 8'd0;
    logic        done;
    logic [2:0]  fix_cnt;
    logic        uncorr, timed_out;

    logic [31:0] loc_reg [2];
    logic [31:0] val_reg [2];
    logic [7:0]  mem     [SECT];
    logic [7:0]  exp_mem [SECT];

    int checks = 0;
    int errors = 0;
    int n_rd = 0, n_wr = 0, n_clr = 0, n_rel = 0, n_go = 0, n_clash = 0;
    int cyc = 0;

    always #2 clk = ~clk;   // 4-unit period: 250 MHz with ns units

    assign res_loc = loc_reg[res_sel];
    assign res_val = val_reg[res_sel];

    corr_apply #(.TMO_CYC(TMO)) u_corr_apply (
        .clk(clk), .rst_n(rst_n), .start(start), .syn_zero(syn_zero),
        .dec_state(dec_state), .dec_cnt(dec_cnt),
        .clr_rd(clr_rd), .calc_go(calc_go), .rel_rd(rel_rd),
        .res_sel(res_sel), .res_loc(res_loc), .res_val(res_val),
        .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_wr(ram_wr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .done(done), .fix_cnt(fix_cnt), .uncorr(uncorr), .timed_out(timed_out)
    );

    // Sector RAM model with one-cycle read latency, plus strobe tallies
    always @(posedge clk) begin
        cyc++;
        if (ram_rd) begin ram_rdata <= mem[ram_addr]; n_rd++; end
        if (ram_wr) begin mem[ram_addr] <= ram_wdata; n_wr++; end
        if (ram_rd && ram_wr) n_clash++;
        if (clr_rd) n_clr++;
        if (calc_go) n_go++;
        if (rel_rd) n_rel++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #600000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    task automatic clear_tallies();
        n_rd = 0; n_wr = 0; n_clr = 0; n_rel = 0; n_go = 0; n_clash = 0;
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < SECT; i++) begin
            mem[i]     = 8'((i * 13) + (seed * 29) + 5);
            exp_mem[i] = mem[i];
        end
    endtask

    function automatic int mem_diffs();
        int d = 0;
        for (int i = 0; i < SECT; i++) if (mem[i] !== exp_mem[i]) d++;
        return d;
    endfunction

    task automatic wait_done(input int limit, input string tag);
        int k = 0;
        while (!done && k < limit) begin
            @(negedge clk);
            k++;
        end
        check(done === 1'b1, tag, int'(done), 1);
    endtask

    // start with syndromes nonzero; returns at the negedge of the calc_go cycle
    task automatic open_run();
        @(negedge clk); start = 1'b1; syn_zero = 1'b0;
        @(negedge clk); start = 1'b0;
        check(clr_rd === 1'b1, "R2 clr_rd after start", int'(clr_rd), 1);
        @(negedge clk);
        check(calc_go === 1'b1, "R2 calc_go after clr_rd", int'(calc_go), 1);
        dec_state = 4'd3;
    endtask

    function automatic int pick_loc(input int k);
        case (k % 10)
            0: return 7;
            1: return 8;
            2: return 519;
            3: return 520;
            4: return 1023;
            5: return 0;
            default: return 8 + ((k * 37) % 512);
        endcase
    endfunction

    task automatic full_run(input int nf, input int l0, input int l1, input int l2,
                            input int l3, input int vbase, input int garb);
        int locs[4];
        int vals[4];
        logic [15:0] lh[4];
        logic [15:0] vh[4];
        int expc = 0;
        locs = '{l0, l1, l2, l3};
        fill(vbase);
        for (int j = 0; j < 4; j++) begin
            vals[j] = ((vbase * 4 + j) * 53) % 255 + 1;
            lh[j] = {6'((garb + j) % 64), 10'(locs[j])};
            vh[j] = {8'(garb * 3 + j), 8'(vals[j])};
        end
        loc_reg[0] = {lh[1], lh[0]}; loc_reg[1] = {lh[3], lh[2]};
        val_reg[0] = {vh[1], vh[0]}; val_reg[1] = {vh[3], vh[2]};
        for (int j = 0; j <= nf; j++) begin
            int l = locs[j] % 1024;
            if (l >= 8 && l <= 519) begin
                exp_mem[519 - l] = exp_mem[519 - l] ^ 8'(vals[j]);
                expc++;
            end
        end
        clear_tallies();
        open_run();
        repeat (3) @(negedge clk);
        check(done === 1'b0 && n_rd == 0, "R3 false finished code ignored", int'(done), 0);
        dec_state = 4'd4;
        repeat (3) @(negedge clk);
        check(done === 1'b0 && n_rd == 0, "R5 busy code keeps polling", n_rd, 0);
        dec_state = (garb % 2 == 0) ? 4'd2 : 4'd3;
        dec_cnt = 2'(nf);
        wait_done(40, "R6 run completes");
        dec_state = 4'd0;
        check(int'(fix_cnt) == expc, "R9 fix_cnt", int'(fix_cnt), expc);
        check(n_wr == expc, "R8 write count", n_wr, expc);
        check(mem_diffs() == 0, "R7 R8 sector contents", mem_diffs(), 0);
        check(n_clash == 0 && n_rd == n_wr, "R10 single access", n_clash, 0);
        check(uncorr === 1'b0 && timed_out === 1'b0, "R9 flags clear", int'({uncorr, timed_out}), 0);
        @(negedge clk);
        check(done === 1'b0, "R9 done is a pulse", int'(done), 0);
        repeat (2) @(negedge clk);
        check(int'(fix_cnt) == expc, "R9 status held", int'(fix_cnt), expc);
    endtask

    initial begin
        loc_reg[0] = '0; loc_reg[1] = '0; val_reg[0] = '0; val_reg[1] = '0;
        fill(0);
        repeat (3) @(negedge clk);
        check(done === 1'b0 && fix_cnt == 3'd0 && !ram_rd && !ram_wr && !clr_rd,
              "reset state", int'(fix_cnt), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: zero syndromes finish in one cycle
        clear_tallies();
        start = 1'b1; syn_zero = 1'b1;
        @(negedge clk); start = 1'b0; syn_zero = 1'b0;
        check(done === 1'b1 && fix_cnt == 3'd0 && !uncorr && !timed_out,
              "R1 immediate finish", int'(done), 1);
        @(negedge clk);
        check(n_clr == 0 && n_go == 0 && n_rd == 0 && mem_diffs() == 0,
              "R1 no decoder or RAM activity", n_clr + n_go + n_rd, 0);

        // R4: busy code on the final window cycle still arms
        clear_tallies();
        open_run();
        repeat (TMO) @(negedge clk);
        check(done === 1'b0, "R4 no timeout before window end", int'(done), 0);
        dec_state = 4'd4;
        repeat (2) @(negedge clk);
        check(done === 1'b0 && timed_out === 1'b0, "R4 arming wins on last cycle",
              int'(timed_out), 0);
        // R5: clean code releases and ends without repairs
        dec_state = 4'd0;
        wait_done(10, "R5 clean code finishes");
        check(n_rel == 1 && fix_cnt == 3'd0 && !uncorr && !timed_out,
              "R5 clean release", n_rel, 1);

        // R4: busy code one cycle late -> timeout
        clear_tallies();
        open_run();
        repeat (TMO + 1) @(negedge clk);
        check(done === 1'b1 && timed_out === 1'b1 && fix_cnt == 3'd0,
              "R4 timeout at window end", int'(timed_out), 1);
        dec_state = 4'd4;
        repeat (4) @(negedge clk);
        check(timed_out === 1'b1 && n_rel == 0 && n_rd == 0, "R4 timeout status held",
              int'(timed_out), 1);
        dec_state = 4'd0;

        // R5: too many errors
        clear_tallies();
        fill(3);
        open_run();
        dec_state = 4'd5;
        repeat (2) @(negedge clk);
        dec_state = 4'd1;
        wait_done(10, "R5 uncorrectable finishes");
        check(uncorr === 1'b1 && n_rel == 1 && n_wr == 0 && fix_cnt == 3'd0,
              "R5 uncorrectable status", int'(uncorr), 1);
        dec_state = 4'd0;
        repeat (2) @(negedge clk);

        // R6 R7 R8: sweep of error counts and location patterns
        for (int nf = 0; nf < 4; nf++) begin
            for (int p = 0; p < 6; p++) begin
                full_run(nf, pick_loc(p * 4 + nf), pick_loc(p * 4 + nf + 1),
                         pick_loc(p * 4 + nf + 2), pick_loc(p * 4 + nf + 3),
                         nf * 6 + p, p * 7 + nf);
            end
        end
        // same byte hit twice, both sector extremes
        full_run(3, 8, 8, 519, 519, 40, 1);
        full_run(3, 8, 519, 300, 9, 41, 2);

        finish_run();
    end

endmodule